// File: doc/BRIEF.md
# PCI Host Special-Command Classifier

This block sits between a host access port and a PCI master sequencer. It keeps a configuration-address register that the host loads through one address, and it classifies every host access to a second address (the configuration-data window) or to a directly mapped interrupt-acknowledge window. For each access it chooses one PCI command: interrupt-acknowledge, special-cycle, type 0 configuration or type 1 configuration. It then presents the address-phase AD, C/BE and even parity as a one-cycle strobe, together with the data-phase word for writes.

The configuration-address register selects the behaviour of the data window. An all-ones device and function number with register zero on bus 0 turns a data-window read into an interrupt-acknowledge and a data-window write into a special cycle. Any non-zero bus number gives a type 1 cycle instead. A clear enable bit suppresses the cycle, and such reads return all ones. A direct read window, chosen by the address-map mode, also issues interrupt-acknowledge. Writes into that window raise a transfer error when error reporting is on.

Top module: `pci_special_cmd_sel`

## Requirements
- R1: After reset every output is zero, and a read of the configuration-address location (default 0xFEC0_0000) returns zero.
- R2: A write to the configuration-address location stores wdata bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register). Bits 30:24 and 1:0 always read back as zero. A read of that location gives `host_rd_valid` and the stored word one cycle later.
- R3: When the enable bit is clear, an access to the configuration-data location (default 0xFEE0_0000) issues no cycle. A read returns 0xFFFF_FFFF with `host_rd_valid`, and a write has no visible effect.
- R4: With enable set, bus 0, device 31, function 7 and register 0, a data-window read issues `cyc_cmd` = 2'b00 (interrupt-acknowledge) with C/BE = 4'b0000 and AD = 0.
- R5: Under the same pattern, a data-window write issues `cyc_cmd` = 2'b01 (special cycle) with C/BE = 4'b0001 and AD = 0. `cyc_data` carries the message in bits 15:0 and the optional field in bits 31:16, both taken from wdata.
- R6: With enable set and a non-zero bus, the access issues `cyc_cmd` = 2'b11 with AD = {8'h00, bus, device, function, register, 2'b01}, even when the other fields hold the special pattern.
- R7: With enable set, bus 0 and a non-special pattern, the access issues `cyc_cmd` = 2'b10 with AD[31:11] one-hot at bit 11+device for device < 21 (zero otherwise), AD[10:8] = function, AD[7:2] = register and AD[1:0] = 00.
- R8: Configuration reads use C/BE 4'b1010 and configuration writes use 4'b1011. `cyc_par` is the XOR of AD[31:0] and C/BE[3:0]. `cyc_data` is wdata for writes and zero for reads.
- R9: In map mode 2'b00, a read of exactly 0xBFFF_FFF0 issues interrupt-acknowledge, and neighbouring addresses issue nothing.
- R10: In map modes 2'b01 and 2'b10, any read in 0xFEF0_0000–0xFEFF_FFFF issues interrupt-acknowledge. Mode 2'b11 has no direct window.
- R11: A write to the active direct window issues no cycle and pulses `host_err` only when `err_report_en` is 1.
- R12: Every result appears one clock after the sampled access as a single-cycle pulse, and at most one of `cyc_valid`, `host_rd_valid` and `host_err` is high. Idle cycles, and addresses outside all windows, produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access present this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 32 | Host write data |
| map_mode | input | 2 | 00 map A, 01 map B, 10 emulation, 11 no window |
| err_report_en | input | 1 | Enables transfer-error responses |
| cyc_valid | output | 1 | PCI cycle request strobe |
| cyc_cmd | output | 2 | 00 int-ack, 01 special, 10 type 0, 11 type 1 |
| cyc_ad | output | 32 | Address-phase AD value |
| cyc_cbe | output | 4 | Address-phase C/BE value |
| cyc_par | output | 1 | Even parity over AD and C/BE |
| cyc_data | output | 32 | Data-phase word |
| host_rd_valid | output | 1 | Host read data returned locally |
| host_rdata | output | 32 | Host read data |
| host_err | output | 1 | Transfer-error response strobe |

## Verification
A corrupt configuration-address register shows at the ports on the very next readback of its location. It also shows on the next data-window access as a wrong command code or wrong AD fields, one clock after that access. A fault in classification appears as the wrong strobe among `cyc_valid`, `host_rd_valid` and `host_err`, or as a wrong C/BE or parity, in the cycle after the access. The sweeps walk every device and function number, several bus and register values, and every map mode, read direction and error setting against the direct window. A mistake therefore surfaces within one access of the pattern it affects.

// File: rtl/pcicls_pkg.sv
package pcicls_pkg;

    localparam int AD_W  = 32;
    localparam int CBE_W = 4;

    typedef enum logic [1:0] {
        CMD_IACK    = 2'b00,
        CMD_SPECIAL = 2'b01,
        CMD_CFG0    = 2'b10,
        CMD_CFG1    = 2'b11
    } pci_cmd_e;

    localparam logic [CBE_W-1:0] CBE_IACK    = 4'b0000;
    localparam logic [CBE_W-1:0] CBE_SPECIAL = 4'b0001;
    localparam logic [CBE_W-1:0] CBE_CFG_RD  = 4'b1010;
    localparam logic [CBE_W-1:0] CBE_CFG_WR  = 4'b1011;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] regn;
    } cfg_addr_t;

    typedef struct packed {
        cfg_addr_t         cfg;
        logic              cyc_valid;
        pci_cmd_e          cmd;
        logic [AD_W-1:0]   ad;
        logic [CBE_W-1:0]  cbe;
        logic              par;
        logic [AD_W-1:0]   data;
        logic              rd_valid;
        logic [AD_W-1:0]   rdata;
        logic              err;
    } sel_state_t;

    function automatic logic [AD_W-1:0] cfg_to_word(cfg_addr_t c);
        return {c.en, 7'b0, c.bus, c.dev, c.func, c.regn, 2'b00};
    endfunction

    function automatic cfg_addr_t word_to_cfg(logic [AD_W-1:0] w);
        cfg_addr_t c;
        c.en   = w[31];
        c.bus  = w[23:16];
        c.dev  = w[15:11];
        c.func = w[10:8];
        c.regn = w[7:2];
        return c;
    endfunction

endpackage

// File: rtl/pcicls_cfg_decode.sv
module pcicls_cfg_decode
    import pcicls_pkg::*;
(
    input  cfg_addr_t cfg,
    input  logic      is_write,
    output logic      issue,
    output logic      rd_ones,
    output pci_cmd_e  cmd
);

    logic on_local_bus;
    logic reserved_pat;

    always_comb begin
        on_local_bus = (cfg.bus == 8'h00);
        reserved_pat = on_local_bus && (&cfg.dev) && (&cfg.func) && (cfg.regn == 6'd0);
        issue   = cfg.en;
        rd_ones = !cfg.en && !is_write;
        if (!on_local_bus)
            cmd = CMD_CFG1;
        else if (reserved_pat)
            cmd = is_write ? CMD_SPECIAL : CMD_IACK;
        else
            cmd = CMD_CFG0;
    end

endmodule

// File: rtl/pcicls_iack_window.sv
module pcicls_iack_window
    import pcicls_pkg::*;
#(
    parameter logic [AD_W-1:0] MAP_A_LOC    = 32'hBFFF_FFF0,
    parameter logic [AD_W-1:0] WIN_BASE     = 32'hFEF0_0000,
    parameter int              WIN_LOW_BITS = 20
) (
    input  logic [AD_W-1:0] addr,
    input  logic [1:0]      mode,
    output logic            hit
);

    localparam int TAG_W = AD_W - WIN_LOW_BITS;

    logic exact_hit;
    logic range_hit;

    always_comb begin
        exact_hit = (addr == MAP_A_LOC);
        range_hit = (addr[AD_W-1:WIN_LOW_BITS] == WIN_BASE[AD_W-1:WIN_LOW_BITS]);
        unique case (mode)
            2'b00:   hit = exact_hit;
            2'b01,
            2'b10:   hit = range_hit;
            default: hit = 1'b0;
        endcase
    end

    // the tag width must leave room for a real compare
    initial begin
        if (TAG_W < 1) $error("window low bits exceed address width");
    end

endmodule

// File: rtl/pcicls_addr_phase.sv
module pcicls_addr_phase
    import pcicls_pkg::*;
(
    input  pci_cmd_e          cmd,
    input  logic              is_write,
    input  logic [7:0]        bus,
    input  logic [4:0]        dev,
    input  logic [2:0]        func,
    input  logic [5:0]        regn,
    output logic [AD_W-1:0]   ad,
    output logic [CBE_W-1:0]  cbe,
    output logic              par
);

    localparam int SEL_LO   = 11;
    localparam int SEL_LINES = AD_W - SEL_LO;

    logic [SEL_LINES-1:0] idsel;

    for (genvar g = 0; g < SEL_LINES; g++) begin : g_idsel
        assign idsel[g] = (dev == 5'(g));
    end

    always_comb begin
        unique case (cmd)
            CMD_IACK: begin
                ad  = '0;
                cbe = CBE_IACK;
            end
            CMD_SPECIAL: begin
                ad  = '0;
                cbe = CBE_SPECIAL;
            end
            CMD_CFG0: begin
                ad  = {idsel, func, regn, 2'b00};
                cbe = is_write ? CBE_CFG_WR : CBE_CFG_RD;
            end
            default: begin
                ad  = {8'h00, bus, dev, func, regn, 2'b01};
                cbe = is_write ? CBE_CFG_WR : CBE_CFG_RD;
            end
        endcase
        par = ^{ad, cbe};
    end

endmodule

// File: rtl/pci_special_cmd_sel.sv
module pci_special_cmd_sel
    import pcicls_pkg::*;
#(
    parameter logic [31:0] CFG_ADDR_LOC = 32'hFEC0_0000,
    parameter logic [31:0] CFG_DATA_LOC = 32'hFEE0_0000,
    parameter logic [31:0] MAP_A_LOC    = 32'hBFFF_FFF0,
    parameter logic [31:0] WIN_BASE     = 32'hFEF0_0000,
    parameter int          WIN_LOW_BITS = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [31:0] host_addr,
    input  logic [31:0] host_wdata,
    input  logic [1:0]  map_mode,
    input  logic        err_report_en,
    output logic        cyc_valid,
    output logic [1:0]  cyc_cmd,
    output logic [31:0] cyc_ad,
    output logic [3:0]  cyc_cbe,
    output logic        cyc_par,
    output logic [31:0] cyc_data,
    output logic        host_rd_valid,
    output logic [31:0] host_rdata,
    output logic        host_err
);

    sel_state_t st_d, st_q;

    logic     hit_cfga_d, hit_cfgd_d, hit_win_d;
    logic     cd_issue_d, cd_rd_ones_d;
    pci_cmd_e cd_cmd_d, sel_cmd_d;
    logic [AD_W-1:0]  ap_ad_d;
    logic [CBE_W-1:0] ap_cbe_d;
    logic             ap_par_d;

    assign hit_cfga_d = (host_addr == CFG_ADDR_LOC);
    assign hit_cfgd_d = (host_addr == CFG_DATA_LOC);

    pcicls_cfg_decode i_cfg_decode (
        .cfg      (st_q.cfg),
        .is_write (host_write),
        .issue    (cd_issue_d),
        .rd_ones  (cd_rd_ones_d),
        .cmd      (cd_cmd_d)
    );

    pcicls_iack_window #(
        .MAP_A_LOC    (MAP_A_LOC),
        .WIN_BASE     (WIN_BASE),
        .WIN_LOW_BITS (WIN_LOW_BITS)
    ) i_iack_window (
        .addr (host_addr),
        .mode (map_mode),
        .hit  (hit_win_d)
    );

    assign sel_cmd_d = hit_cfgd_d ? cd_cmd_d : CMD_IACK;

    pcicls_addr_phase i_addr_phase (
        .cmd      (sel_cmd_d),
        .is_write (host_write),
        .bus      (st_q.cfg.bus),
        .dev      (st_q.cfg.dev),
        .func     (st_q.cfg.func),
        .regn     (st_q.cfg.regn),
        .ad       (ap_ad_d),
        .cbe      (ap_cbe_d),
        .par      (ap_par_d)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cyc_valid = 1'b0;
        st_d.cmd       = CMD_IACK;
        st_d.ad        = '0;
        st_d.cbe       = '0;
        st_d.par       = 1'b0;
        st_d.data      = '0;
        st_d.rd_valid  = 1'b0;
        st_d.rdata     = '0;
        st_d.err       = 1'b0;

        if (host_valid) begin
            if (hit_cfga_d) begin
                if (host_write) begin
                    st_d.cfg = word_to_cfg(host_wdata);
                end else begin
                    st_d.rd_valid = 1'b1;
                    st_d.rdata    = cfg_to_word(st_q.cfg);
                end
            end else if (hit_cfgd_d) begin
                if (cd_issue_d) begin
                    st_d.cyc_valid = 1'b1;
                    st_d.cmd       = sel_cmd_d;
                    st_d.ad        = ap_ad_d;
                    st_d.cbe       = ap_cbe_d;
                    st_d.par       = ap_par_d;
                    st_d.data      = host_write ? host_wdata : '0;
                end else if (cd_rd_ones_d) begin
                    st_d.rd_valid = 1'b1;
                    st_d.rdata    = '1;
                end
            end else if (hit_win_d) begin
                if (host_write) begin
                    st_d.err = err_report_en;
                end else begin
                    st_d.cyc_valid = 1'b1;
                    st_d.cmd       = sel_cmd_d;
                    st_d.ad        = ap_ad_d;
                    st_d.cbe       = ap_cbe_d;
                    st_d.par       = ap_par_d;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_valid     = st_q.cyc_valid;
    assign cyc_cmd       = st_q.cmd;
    assign cyc_ad        = st_q.ad;
    assign cyc_cbe       = st_q.cbe;
    assign cyc_par       = st_q.par;
    assign cyc_data      = st_q.data;
    assign host_rd_valid = st_q.rd_valid;
    assign host_rdata    = st_q.rdata;
    assign host_err      = st_q.err;

endmodule

// File: rtl/pcicls_checker.sv
module pcicls_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_valid,
    input logic        host_write,
    input logic        err_report_en,
    input logic        cyc_valid,
    input logic [1:0]  cyc_cmd,
    input logic [31:0] cyc_ad,
    input logic [3:0]  cyc_cbe,
    input logic        cyc_par,
    input logic        host_rd_valid,
    input logic        host_err
);

    a_r8_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> ((^{cyc_ad, cyc_cbe, cyc_par}) == 1'b0));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> (!cyc_valid && !host_rd_valid && !host_err));

    a_r12_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cyc_valid, host_rd_valid, host_err}));

    a_r4_iack_blank_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_cmd == 2'b00) |-> (cyc_ad == 32'd0 && cyc_cbe == 4'b0000));

    a_r5_special_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_cmd == 2'b01) |-> (cyc_cbe == 4'b0001 && cyc_ad == 32'd0 && $past(host_write)));

    a_r6_type1_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_cmd == 2'b11) |-> (cyc_ad[1:0] == 2'b01 && cyc_ad[23:16] != 8'h00));

    a_r11_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> ($past(err_report_en) && $past(host_write) && $past(host_valid)));

endmodule

bind pci_special_cmd_sel pcicls_checker i_pcicls_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_valid    (host_valid),
    .host_write    (host_write),
    .err_report_en (err_report_en),
    .cyc_valid     (cyc_valid),
    .cyc_cmd       (cyc_cmd),
    .cyc_ad        (cyc_ad),
    .cyc_cbe       (cyc_cbe),
    .cyc_par       (cyc_par),
    .host_rd_valid (host_rd_valid),
    .host_err      (host_err)
);

// File: tb/test_pci_special_cmd_sel.sv
module test_pci_special_cmd_sel;

    localparam logic [31:0] CFGA = 32'hFEC0_0000;
    localparam logic [31:0] CFGD = 32'hFEE0_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_valid, host_write;
    logic [31:0] host_addr, host_wdata;
    logic [1:0]  map_mode;
    logic        err_report_en;
    logic        cyc_valid;
    logic [1:0]  cyc_cmd;
    logic [31:0] cyc_ad;
    logic [3:0]  cyc_cbe;
    logic        cyc_par;
    logic [31:0] cyc_data;
    logic        host_rd_valid;
    logic [31:0] host_rdata;
    logic        host_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] cfg_m;

    always #4 clk = ~clk;

    pci_special_cmd_sel i_pci_special_cmd_sel (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .map_mode(map_mode),
        .err_report_en(err_report_en), .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd),
        .cyc_ad(cyc_ad), .cyc_cbe(cyc_cbe), .cyc_par(cyc_par), .cyc_data(cyc_data),
        .host_rd_valid(host_rd_valid), .host_rdata(host_rdata), .host_err(host_err)
    );

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_quiet(input string tag);
        cmp(tag, "quiet", {29'd0, cyc_valid, host_rd_valid, host_err}, 32'd0);
        cmp(tag, "quiet ad", cyc_ad | cyc_data | host_rdata | {28'd0, cyc_cbe}, 32'd0);
    endtask

    task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd);
        logic        e_v = 1'b0, e_rv = 1'b0, e_err = 1'b0;
        logic [1:0]  e_cmd = 2'b00;
        logic [31:0] e_ad = '0, e_data = '0, e_rd = '0;
        logic [3:0]  e_cbe = '0;
        logic [7:0]  bus  = cfg_m[23:16];
        logic [4:0]  dev  = cfg_m[15:11];
        logic [2:0]  fn   = cfg_m[10:8];
        logic [5:0]  rg   = cfg_m[7:2];
        logic        hitw;
        string       tag = "R12";
        hitw = (map_mode == 2'b00) ? (addr == 32'hBFFF_FFF0)
             : (map_mode != 2'b11) && (addr[31:20] == 12'hFEF);
        if (addr == CFGA) begin
            tag = "R2";
            if (wr) cfg_m = wd & 32'h80FF_FFFC;
            else begin e_rv = 1'b1; e_rd = cfg_m; end
        end else if (addr == CFGD) begin
            if (!cfg_m[31]) begin
                tag = "R3";
                if (!wr) begin e_rv = 1'b1; e_rd = 32'hFFFF_FFFF; end
            end else begin
                e_v = 1'b1;
                e_data = wr ? wd : 32'd0;
                e_cbe = wr ? 4'b1011 : 4'b1010;
                if (bus != 0) begin
                    tag = "R6"; e_cmd = 2'b11;
                    e_ad = (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | (32'(rg) << 2) | 32'd1;
                end else if (dev == 31 && fn == 7 && rg == 0) begin
                    if (wr) begin tag = "R5"; e_cmd = 2'b01; e_cbe = 4'b0001; end
                    else    begin tag = "R4"; e_cmd = 2'b00; e_cbe = 4'b0000; end
                end else begin
                    tag = "R7"; e_cmd = 2'b10;
                    e_ad = ((dev < 21) ? (32'd1 << (11 + dev)) : 32'd0) | (32'(fn) << 8) | (32'(rg) << 2);
                end
            end
        end else if (hitw) begin
            if (wr) begin tag = "R11"; e_err = err_report_en; end
            else begin
                tag = (map_mode == 2'b00) ? "R9" : "R10";
                e_v = 1'b1;
            end
        end
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0; host_addr = '0; host_wdata = '0;
        cmp(tag, "strobes", {29'd0, cyc_valid, host_rd_valid, host_err}, {29'd0, e_v, e_rv, e_err});
        cmp(tag, "cmd", {30'd0, cyc_cmd}, {30'd0, e_cmd});
        cmp(tag, "ad", cyc_ad, e_ad);
        cmp(e_v ? "R8" : tag, "cbe", {28'd0, cyc_cbe}, {28'd0, e_cbe});
        cmp("R8", "par", {31'd0, cyc_par}, {31'd0, e_v ? ^{e_ad, e_cbe} : 1'b0});
        cmp(e_v ? "R8" : tag, "data", cyc_data, e_data);
        cmp(tag, "rdata", host_rdata, e_rd);
        @(negedge clk);
        check_quiet("R12");
    endtask

    task automatic set_cfg(input logic en, input logic [7:0] bus, input logic [4:0] dev,
                           input logic [2:0] fn, input logic [5:0] rg);
        access(1'b1, CFGA, {en, 7'h7F, bus, dev, fn, rg, 2'b11});
        access(1'b0, CFGA, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] addrs [8];
        addrs = '{32'hBFFF_FFF0, 32'hBFFF_FFF4, 32'hBFFF_FFEC, 32'hFEF0_0000,
                  32'hFEFF_FFFC, 32'hFEEF_FFFC, 32'hFF00_0000, 32'h0000_1000};
        cfg_m = '0;
        rst_n = 1'b0; host_valid = 1'b0; host_write = 1'b0; host_addr = '0;
        host_wdata = '0; map_mode = 2'b00; err_report_en = 1'b0;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        access(1'b0, CFGA, 32'd0);                 // R1 readback of zero
        access(1'b0, CFGD, 32'd0);                 // R3 disabled read
        access(1'b1, CFGD, 32'h1234_5678);         // R3 disabled write
        for (int d = 0; d < 32; d++) begin
            set_cfg(1'b1, 8'h00, 5'(d), 3'd7, 6'd0);
            access(1'b0, CFGD, 32'd0);
            access(1'b1, CFGD, {16'hA5A5 ^ 16'(d), 16'h1234 + 16'(d)});
        end
        for (int f = 0; f < 8; f++) begin
            for (int r = 0; r < 3; r++) begin
                set_cfg(1'b1, 8'h00, 5'd31, 3'(f), (r == 0) ? 6'd0 : (r == 1) ? 6'd1 : 6'd63);
                access(1'b0, CFGD, 32'd0);
                access(1'b1, CFGD, 32'hCAFE_0000 | 32'(f * 8 + r));
            end
        end
        for (int b = 0; b < 4; b++) begin
            logic [7:0] bv;
            bv = (b == 0) ? 8'h01 : (b == 1) ? 8'h02 : (b == 2) ? 8'h80 : 8'hFF;
            set_cfg(1'b1, bv, 5'd31, 3'd7, 6'd0);
            access(1'b0, CFGD, 32'd0);
            access(1'b1, CFGD, 32'h0BAD_F00D);
            set_cfg(1'b1, bv, 5'd3, 3'd2, 6'd5);
            access(1'b0, CFGD, 32'd0);
            access(1'b1, CFGD, 32'h0000_FFFF);
        end
        set_cfg(1'b0, 8'h00, 5'd31, 3'd7, 6'd0);
        access(1'b0, CFGD, 32'd0);
        access(1'b1, CFGD, 32'h5555_AAAA);
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                map_mode = 2'(m);
                err_report_en = 1'(e);
                for (int a = 0; a < 8; a++) begin
                    access(1'b0, addrs[a], 32'd0);
                    access(1'b1, addrs[a], 32'h1111_2222);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule